// File: doc/BRIEF.md
# Crate Backplane Command Cycle Master

This block is the master side of a parallel crate backplane. A host hands it one request: a slot number, a 5-bit register index, a 4-bit operation code, a 24-bit write word and a 4-bit stretch factor. The block then runs one complete backplane command. It raises the one-hot slot select line together with the register index and the operation code, and lets them settle. It then issues a first strobe, during which the addressed module either takes the write word or drives its read word. A second strobe follows, at whose last clock the read word and the two response bits are captured. After a recovery gap the block reports the result to the host with a one-cycle done pulse.

Operation codes 8 to 15 are writes and 0 to 7 are reads. A slot number outside 1..23 never reaches the backplane. The block rejects it at once and reports it as not accepted. With a 50 MHz clock the four phases default to 10, 15, 15 and 10 clocks, which is one microsecond. Every phase is multiplied by (stretch+1) so that slow modules get more time. Three crate-wide control lines (reset all, clear, hold-off) are driven from host levels in any state.

The controller is a seven-state machine. The states are IDLE, SETTLE, STROBE1, STROBE2, RECOVER, REJECT and DONE. The transitions are:
- IDLE to SETTLE on a request with a valid slot.
- IDLE to REJECT on a request with a bad slot.
- SETTLE to STROBE1, STROBE1 to STROBE2 and STROBE2 to RECOVER, each when its phase timer runs out.
- RECOVER to DONE when its phase timer runs out, and REJECT to DONE after one cycle.
- DONE to IDLE after one cycle.

Top module: `crate_cycle_master`

## Requirements
- R1: After reset, busy, done, both strobes, all slot selects, the write enable and the three crate control lines are low.
- R2: A request is taken only in IDLE. busy is high from the cycle after acceptance through the done cycle: 50*(k+1)+1 cycles for a valid slot, where k is the stretch value.
- R3: For a valid slot s, bus_sel has exactly bit s-1 set, and bus_sub and bus_func carry the request fields, from SETTLE through STROBE2. All three are zero in RECOVER, DONE and IDLE.
- R4: SETTLE lasts 10*(k+1) cycles, STROBE1 lasts 15*(k+1), STROBE2 lasts 15*(k+1) and RECOVER lasts 10*(k+1). k is sampled at acceptance, and the two strobes never overlap.
- R5: When bit 3 of the operation code is 1 (write), bus_wdata_en is high and bus_wdata carries the write word from SETTLE through STROBE2. For reads, bus_wdata_en stays low.
- R6: bus_rdata, bus_q and bus_x are sampled at the last clock of STROBE2. rsp_rdata is the sampled word for a read and zero for a write. The response outputs hold until the next acceptance.
- R7: done is a single-cycle pulse after RECOVER, and rsp_accept equals the sampled bus_x.
- R8: A slot of 0 or above 23 produces no select line and no strobe. done follows two cycles after acceptance, with rsp_accept, rsp_q and rsp_rdata all zero.
- R9: bus_init, bus_clear and bus_inhibit equal host_init, host_clear and host_inhibit one cycle later, in every state.
- R10: A request raised during the done cycle is ignored. No cycle starts, and the held response is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_station | input | 5 | Slot number, 1..23 valid |
| req_sub | input | 5 | Register index within the module |
| req_func | input | 4 | Operation code, bit 3 set means write |
| req_wdata | input | 24 | Write word |
| req_stretch | input | 4 | Phase multiplier minus one |
| host_init | input | 1 | Crate-wide reset request level |
| host_clear | input | 1 | Crate-wide clear request level |
| host_inhibit | input | 1 | Crate-wide hold-off level |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 24 | Captured read word |
| rsp_q | output | 1 | Captured module status bit |
| rsp_accept | output | 1 | Captured acceptance bit |
| bus_sel | output | 23 | One-hot slot select lines |
| bus_sub | output | 5 | Register index lines |
| bus_func | output | 4 | Operation code lines |
| bus_wdata | output | 24 | Write lines |
| bus_wdata_en | output | 1 | Write lines driven |
| bus_s1 | output | 1 | First strobe |
| bus_s2 | output | 1 | Second strobe |
| bus_rdata | input | 24 | Read lines |
| bus_q | input | 1 | Module status response |
| bus_x | input | 1 | Module acceptance response |
| bus_init | output | 1 | Crate reset line |
| bus_clear | output | 1 | Crate clear line |
| bus_inhibit | output | 1 | Crate hold-off line |

## Verification
Two events can land on the same clock. The first is a host request raised during the done pulse, which is the first cycle an eager host could retry. The bench raises a request exactly in the done cycle. It then expects busy to stay low, no further done pulse to reach the scoreboard, and the earlier read word to remain on rsp_rdata. The second is a control-line change during a live command: the hold-off line is toggled mid-cycle, and it must follow at once while the command's phase counts stay exact. The bench model also drives garbage on the read and response lines outside the second strobe, so that a capture at any other point shows up as a data mismatch.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_STROBE1,
        ST_STROBE2,
        ST_RECOVER,
        ST_REJECT,
        ST_DONE
    } ccm_state_e;

endpackage

// File: rtl/ccm_phase_timer.sv
`timescale 1ns/1ps
module ccm_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ccm_slot_decode.sv
`timescale 1ns/1ps
module ccm_slot_decode #(
    parameter int N_SLOTS = 23,
    parameter int SLOT_W  = 5
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic               enable,
    output logic [N_SLOTS-1:0] sel
);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_line
        assign sel[i] = enable && (slot == SLOT_W'(i + 1));
    end

endmodule

// File: rtl/ccm_resp_capture.sv
`timescale 1ns/1ps
module ccm_resp_capture #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              is_read,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_q,
    input  logic              bus_x,
    output logic [DATA_W-1:0] rdata,
    output logic              q,
    output logic              x
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rdata <= '0;
            q     <= 1'b0;
            x     <= 1'b0;
        end else if (cap) begin
            rdata <= is_read ? bus_rdata : '0;
            q     <= bus_q;
            x     <= bus_x;
        end
    end

endmodule

// File: rtl/ccm_ctl_lines.sv
`timescale 1ns/1ps
module ccm_ctl_lines #(
    parameter int N_LINES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] host_lvl,
    output logic [N_LINES-1:0] bus_lvl
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) bus_lvl[i] <= 1'b0;
            else        bus_lvl[i] <= host_lvl[i];
        end
    end

endmodule

// File: rtl/crate_cycle_master.sv
`timescale 1ns/1ps
module crate_cycle_master
    import ccm_pkg::*;
#(
    parameter int N_SLOTS     = 23,
    parameter int SLOT_W      = 5,
    parameter int SUB_W       = 5,
    parameter int FUNC_W      = 4,
    parameter int DATA_W      = 24,
    parameter int STRETCH_W   = 4,
    parameter int SETTLE_CLKS = 10,
    parameter int S1_CLKS     = 15,
    parameter int S2_CLKS     = 15,
    parameter int REC_CLKS    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SLOT_W-1:0]  req_station,
    input  logic [SUB_W-1:0]   req_sub,
    input  logic [FUNC_W-1:0]  req_func,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [STRETCH_W-1:0] req_stretch,
    input  logic               host_init,
    input  logic               host_clear,
    input  logic               host_inhibit,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_q,
    output logic               rsp_accept,
    output logic [N_SLOTS-1:0] bus_sel,
    output logic [SUB_W-1:0]   bus_sub,
    output logic [FUNC_W-1:0]  bus_func,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_wdata_en,
    output logic               bus_s1,
    output logic               bus_s2,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_q,
    input  logic               bus_x,
    output logic               bus_init,
    output logic               bus_clear,
    output logic               bus_inhibit
);

    localparam int MAX_A    = (SETTLE_CLKS > REC_CLKS) ? SETTLE_CLKS : REC_CLKS;
    localparam int MAX_B    = (S1_CLKS > S2_CLKS) ? S1_CLKS : S2_CLKS;
    localparam int MAX_BASE = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_BASE * (2 ** STRETCH_W) + 1);

    ccm_state_e state_q, state_d;

    logic [SLOT_W-1:0]    station_q;
    logic [SUB_W-1:0]     sub_q;
    logic [FUNC_W-1:0]    func_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [STRETCH_W-1:0] stretch_q;

    logic                 accept;
    logic                 station_ok;
    logic                 tmr_load;
    logic                 tmr_expired;
    logic                 cap_resp;
    logic [CNT_W-1:0]     base_sel;
    logic [CNT_W-1:0]     mult;
    logic [CNT_W-1:0]     load_val;
    logic [STRETCH_W-1:0] k_sel;
    logic                 addr_phase;
    logic                 is_write;
    logic [2:0]           host_lvl;
    logic [2:0]           bus_lvl;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign station_ok = (req_station != '0) && (32'(req_station) <= N_SLOTS);
    assign is_write   = func_q[FUNC_W-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            station_q <= '0;
            sub_q     <= '0;
            func_q    <= '0;
            wdata_q   <= '0;
            stretch_q <= '0;
        end else if (accept) begin
            station_q <= req_station;
            sub_q     <= req_sub;
            func_q    <= req_func;
            wdata_q   <= req_wdata;
            stretch_q <= req_stretch;
        end
    end

    // next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        cap_resp = 1'b0;
        base_sel = CNT_W'(SETTLE_CLKS);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (station_ok) begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                        base_sel = CNT_W'(SETTLE_CLKS);
                    end else begin
                        state_d = ST_REJECT;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE1;
                    tmr_load = 1'b1;
                    base_sel = CNT_W'(S1_CLKS);
                end
            end
            ST_STROBE1: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE2;
                    tmr_load = 1'b1;
                    base_sel = CNT_W'(S2_CLKS);
                end
            end
            ST_STROBE2: begin
                if (tmr_expired) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    cap_resp = 1'b1;
                    base_sel = CNT_W'(REC_CLKS);
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_REJECT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign k_sel    = (state_q == ST_IDLE) ? req_stretch : stretch_q;
    assign mult     = CNT_W'(k_sel) + CNT_W'(1);
    assign load_val = base_sel * mult - CNT_W'(1);

    ccm_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (load_val),
        .expired  (tmr_expired)
    );

    // Moore outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
        addr_phase   = (state_q == ST_SETTLE) || (state_q == ST_STROBE1) ||
                       (state_q == ST_STROBE2);
        bus_s1       = (state_q == ST_STROBE1);
        bus_s2       = (state_q == ST_STROBE2);
        bus_sub      = addr_phase ? sub_q : '0;
        bus_func     = addr_phase ? func_q : '0;
        bus_wdata_en = addr_phase && is_write;
        bus_wdata    = bus_wdata_en ? wdata_q : '0;
    end

    ccm_slot_decode #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_dec (
        .slot   (station_q),
        .enable (addr_phase),
        .sel    (bus_sel)
    );

    ccm_resp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .cap       (cap_resp),
        .is_read   (!is_write),
        .bus_rdata (bus_rdata),
        .bus_q     (bus_q),
        .bus_x     (bus_x),
        .rdata     (rsp_rdata),
        .q         (rsp_q),
        .x         (rsp_accept)
    );

    assign host_lvl = {host_inhibit, host_clear, host_init};

    ccm_ctl_lines #(.N_LINES(3)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_lvl (host_lvl),
        .bus_lvl  (bus_lvl)
    );

    assign bus_init    = bus_lvl[0];
    assign bus_clear   = bus_lvl[1];
    assign bus_inhibit = bus_lvl[2];

endmodule

// File: rtl/ccm_checker.sv
`timescale 1ns/1ps
module ccm_checker #(
    parameter int N_SLOTS = 23,
    parameter int FUNC_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_init,
    input logic               host_clear,
    input logic               host_inhibit,
    input logic               busy,
    input logic               done,
    input logic [N_SLOTS-1:0] bus_sel,
    input logic [FUNC_W-1:0]  bus_func,
    input logic               bus_wdata_en,
    input logic               bus_s1,
    input logic               bus_s2,
    input logic               bus_init,
    input logic               bus_clear,
    input logic               bus_inhibit
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel));

    assert_strobe_has_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_s1 || bus_s2) |-> ($countones(bus_sel) == 1));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_s1 && bus_s2));

    assert_s2_after_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(bus_s2)) |-> $past(bus_s1));

    assert_wen_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_en |-> bus_func[FUNC_W-1]);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_s1 && !bus_s2 && (bus_sel == '0)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_ctl_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (bus_init == $past(host_init) && bus_clear == $past(host_clear) &&
                     bus_inhibit == $past(host_inhibit)));

endmodule

bind crate_cycle_master ccm_checker #(.N_SLOTS(N_SLOTS), .FUNC_W(FUNC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_init    (host_init),
    .host_clear   (host_clear),
    .host_inhibit (host_inhibit),
    .busy         (busy),
    .done         (done),
    .bus_sel      (bus_sel),
    .bus_func     (bus_func),
    .bus_wdata_en (bus_wdata_en),
    .bus_s1       (bus_s1),
    .bus_s2       (bus_s2),
    .bus_init     (bus_init),
    .bus_clear    (bus_clear),
    .bus_inhibit  (bus_inhibit)
);

// File: tb/sim_crate_cycle_master.sv
`timescale 1ns/1ps
module sim_crate_cycle_master;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_station = '0;
    logic [4:0]  req_sub = '0;
    logic [3:0]  req_func = '0;
    logic [23:0] req_wdata = '0;
    logic [3:0]  req_stretch = '0;
    logic        host_init = 1'b0, host_clear = 1'b0, host_inhibit = 1'b0;
    logic        busy, done, rsp_q, rsp_accept;
    logic [23:0] rsp_rdata;
    logic [22:0] bus_sel;
    logic [4:0]  bus_sub;
    logic [3:0]  bus_func;
    logic [23:0] bus_wdata;
    logic        bus_wdata_en, bus_s1, bus_s2;
    logic [23:0] bus_rdata = '0;
    logic        bus_q = 1'b0, bus_x = 1'b0;
    logic        bus_init, bus_clear, bus_inhibit;

    crate_cycle_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_station(req_station),
        .req_sub(req_sub), .req_func(req_func), .req_wdata(req_wdata),
        .req_stretch(req_stretch), .host_init(host_init), .host_clear(host_clear),
        .host_inhibit(host_inhibit), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .rsp_q(rsp_q), .rsp_accept(rsp_accept), .bus_sel(bus_sel), .bus_sub(bus_sub),
        .bus_func(bus_func), .bus_wdata(bus_wdata), .bus_wdata_en(bus_wdata_en),
        .bus_s1(bus_s1), .bus_s2(bus_s2), .bus_rdata(bus_rdata), .bus_q(bus_q),
        .bus_x(bus_x), .bus_init(bus_init), .bus_clear(bus_clear),
        .bus_inhibit(bus_inhibit)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string rq, input string what, input longint act,
                       input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    typedef struct {
        int          st;
        logic [4:0]  sub;
        logic [3:0]  fn;
        logic [23:0] wd;
        int          k;
        logic [23:0] rd;
        logic        q;
        logic        acc;
        bit          rej;
    } exp_t;

    exp_t sbq[$];

    // module model: correct values only during the second strobe
    logic [23:0] cur_rd = '0;
    logic        cur_q = 1'b0, cur_x = 1'b0;
    always @(negedge clk) begin
        bus_rdata <= bus_s2 ? cur_rd : ~cur_rd;
        bus_q     <= bus_s2 ? cur_q  : ~cur_q;
        bus_x     <= bus_s2 ? cur_x  : ~cur_x;
    end

    task automatic start(input int st, input logic [4:0] sub, input logic [3:0] fn,
                         input logic [23:0] wd, input int k, input logic [23:0] rd,
                         input logic q, input logic x);
        exp_t e;
        while (busy) @(negedge clk);
        cur_rd = rd; cur_q = q; cur_x = x;
        e.st = st; e.sub = sub; e.fn = fn; e.wd = wd; e.k = k;
        e.rej = (st < 1) || (st > 23);
        e.rd  = (e.rej || fn[3]) ? 24'h0 : rd;
        e.q   = e.rej ? 1'b0 : q;
        e.acc = e.rej ? 1'b0 : x;
        sbq.push_back(e);
        req_station = st[4:0]; req_sub = sub; req_func = fn; req_wdata = wd;
        req_stretch = k[3:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic issue(input int st, input logic [4:0] sub, input logic [3:0] fn,
                         input logic [23:0] wd, input int k, input logic [23:0] rd,
                         input logic q, input logic x);
        start(st, sub, fn, wd, k, rd, q, x);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    int n_busy = 0, n_set = 0, n_s1 = 0, n_s2 = 0, n_rec = 0;
    bit seen_s1 = 0, seen_s2 = 0, any_sel = 0;
    logic [22:0] sel_at = '0;
    logic [4:0]  sub_at = '0;
    logic [3:0]  fn_at = '0;
    logic        wen_at = 1'b0;
    logic [23:0] wd_at = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) n_busy++;
            if (busy && !done) begin
                if (bus_sel != '0) any_sel = 1;
                if (bus_s1) begin
                    n_s1++; seen_s1 = 1;
                    sel_at = bus_sel; sub_at = bus_sub; fn_at = bus_func;
                    wen_at = bus_wdata_en; wd_at = bus_wdata;
                end else if (bus_s2) begin
                    n_s2++; seen_s2 = 1;
                end else if (bus_sel != '0 && !seen_s1) begin
                    n_set++;
                end else if (seen_s2 && bus_sel == '0) begin
                    n_rec++;
                end
            end
            if (done) begin
                if (sbq.size() == 0) begin
                    chk("R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (e.rej) begin
                        chk("R8", "busy cycles", n_busy, 2);
                        chk("R8", "select seen", any_sel, 0);
                        chk("R8", "strobe cycles", n_s1 + n_s2, 0);
                        chk("R8", "rdata", rsp_rdata, 0);
                        chk("R8", "q", rsp_q, 0);
                        chk("R8", "accept", rsp_accept, 0);
                    end else begin
                        chk("R2", "busy cycles", n_busy, 50 * (e.k + 1) + 1);
                        chk("R4", "settle cycles", n_set, 10 * (e.k + 1));
                        chk("R4", "s1 cycles", n_s1, 15 * (e.k + 1));
                        chk("R4", "s2 cycles", n_s2, 15 * (e.k + 1));
                        chk("R4", "recovery cycles", n_rec, 10 * (e.k + 1));
                        chk("R3", "select", sel_at, 23'(1) << (e.st - 1));
                        chk("R3", "sub", sub_at, e.sub);
                        chk("R3", "func", fn_at, e.fn);
                        chk("R5", "write enable", wen_at, e.fn[3]);
                        if (e.fn[3]) chk("R5", "write word", wd_at, e.wd);
                        chk("R6", "rdata", rsp_rdata, e.rd);
                        chk("R6", "q", rsp_q, e.q);
                        chk("R7", "accept", rsp_accept, e.acc);
                    end
                end
                n_busy = 0; n_set = 0; n_s1 = 0; n_s2 = 0; n_rec = 0;
                seen_s1 = 0; seen_s2 = 0; any_sel = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "strobes", {bus_s1, bus_s2}, 0);
        chk("R1", "select", bus_sel, 0);
        chk("R1", "write enable", bus_wdata_en, 0);
        chk("R1", "ctl lines", {bus_init, bus_clear, bus_inhibit}, 0);

        issue(5, 5'd3, 4'd2, 24'h000000, 0, 24'h123456, 1'b1, 1'b1);
        issue(23, 5'd31, 4'hF, 24'hABCDEF, 1, 24'h777777, 1'b0, 1'b1);
        issue(1, 5'd0, 4'd0, 24'h0, 2, 24'h0F0F0F, 1'b0, 1'b0);
        issue(0, 5'd1, 4'd1, 24'h0, 0, 24'h111111, 1'b1, 1'b1);
        issue(24, 5'd1, 4'd9, 24'h222222, 0, 24'h333333, 1'b1, 1'b1);
        issue(31, 5'd2, 4'd3, 24'h0, 3, 24'h444444, 1'b1, 1'b1);
        issue(12, 5'd8, 4'd8, 24'h5A5A5A, 0, 24'h999999, 1'b1, 1'b0);
        issue(9, 5'd15, 4'd7, 24'h0, 15, 24'hFEDCBA, 1'b1, 1'b1);

        // R10: request raised during the done cycle is ignored
        start(7, 5'd4, 4'd1, 24'h0, 0, 24'hC0FFEE, 1'b1, 1'b1);
        while (!done) @(negedge clk);
        req_station = 5'd3; req_sub = 5'd1; req_func = 4'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "busy after done", busy, 0);
        repeat (5) @(negedge clk);
        chk("R10", "busy later", busy, 0);
        chk("R10", "held rdata", rsp_rdata, 24'hC0FFEE);
        chk("R6", "held accept", rsp_accept, 1);

        // R9: control lines in idle
        host_init = 1'b1;
        @(negedge clk);
        chk("R9", "init high", bus_init, 1);
        host_init = 1'b0; host_clear = 1'b1;
        @(negedge clk);
        chk("R9", "init low", bus_init, 0);
        chk("R9", "clear high", bus_clear, 1);
        host_clear = 1'b0;
        @(negedge clk);
        chk("R9", "clear low", bus_clear, 0);

        // R9: hold-off toggled during a live cycle
        start(17, 5'd6, 4'd10, 24'h13579B, 0, 24'h0, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        host_inhibit = 1'b1;
        @(negedge clk);
        chk("R9", "inhibit mid-cycle", bus_inhibit, 1);
        chk("R9", "still busy", busy, 1);
        host_inhibit = 1'b0;
        @(negedge clk);
        chk("R9", "inhibit released", bus_inhibit, 0);
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2", "scoreboard drained", sbq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule